// File: doc/BRIEF.md
# ADC Sequencer Freeze and Stop Controller

This block sits beside a queued analog-to-digital conversion sequencer and governs two quiet modes. The first is a debug freeze: when a debugger requests a halt and freezing has been enabled, the controller halts the sequencer at a clean point. It waits for the conversion in progress unless no queue is running, or unless the active queue's mode changes or queue 2 aborts while it waits; in those cases it halts at once. While halted, it holds the conversion clock divider and the periodic/interval timer in reset, drops incoming trigger pulses, and keeps the command-word pointer of the interrupted queue so that the sequencer can pick up again.

The second mode is a low-power stop. When stop is enabled and requested, the controller holds the timer and the conversion clock in reset. It also resets the second-level control and status registers and tells the bus side, register group by register group, which kind of access is still allowed. The bus interface itself stays alive in both modes. On leaving freeze, a single-cycle resume pulse is raised together with the saved pointer.

Top module: `adcfz_ctl`

## Requirements
- R1: A freeze request has no effect while the freeze-enable input is low; `frozen` stays 0.
- R2: With freeze enabled and no queue active, `frozen` is 1 after the first clock edge that samples the request.
- R3: With a queue active and a conversion busy, `frozen` stays 0 until the edge that samples `conv_done` high; after that edge it is 1.
- R4: While waiting for a conversion, a sampled `qmode_chg` or `q2_abort` makes `frozen` 1 after that same edge, without `conv_done`.
- R5: While `frozen` is 1, `qclk_hold` and `pit_hold` are 1; once the request is sampled low, `frozen` and both holds fall after that edge (holds stay up if stopped).
- R6: On entry to freeze with a queue active, `saved_ptr` takes the `qptr` value sampled at the entry edge; entry with no queue active leaves `saved_ptr` unchanged.
- R7: `trig_cap` is `trig_in` sampled at each edge, delayed one cycle, except that it is all zeros when `frozen` was 1 at that edge.
- R8: `stopped` is 1 after an edge sampling `stop_req` and `stop_en` both high, and is otherwise 0; while stopped, `pit_hold`, `qclk_hold` and `ctl_rst` are 1.
- R9: Access codes are 2'b10 for full, 2'b01 for read-only and 2'b00 for none. When not stopped, all four groups read 2'b10. When stopped, `acc_cfg` is 2'b10, `acc_ctl0` and `acc_ctl12` are 2'b01, and `acc_ram` is 2'b00. Freeze does not change the codes.
- R10: `resume` is 1 for exactly one cycle, the first cycle in which `frozen` is 0 after a freeze, and `saved_ptr` is held during it.
- R11: While `rst_n` is low, all outputs are in the running state: not frozen, not stopped, no holds, no triggers, no resume, saved pointer 0, full access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frz_req | input | 1 | Debug freeze request |
| frz_en | input | 1 | Freeze-enable configuration bit |
| stop_en | input | 1 | Stop-enable configuration bit |
| stop_req | input | 1 | Low-power stop request |
| q_active | input | 1 | A queue is executing |
| conv_busy | input | 1 | A conversion is in progress |
| conv_done | input | 1 | The conversion in progress completes this cycle |
| qmode_chg | input | 1 | The active queue's operating mode was changed |
| q2_abort | input | 1 | Queue 2 aborted |
| trig_in | input | N_TRIG | External trigger pulses |
| qptr | input | PTR_W | Current command-word pointer of the active queue |
| frozen | output | 1 | Freeze status |
| stopped | output | 1 | Stop status |
| qclk_hold | output | 1 | Reset hold for the conversion clock divider |
| pit_hold | output | 1 | Reset hold for the periodic/interval timer |
| saved_ptr | output | PTR_W | Pointer kept for resume |
| resume | output | 1 | One-cycle pulse on leaving freeze |
| trig_cap | output | N_TRIG | Triggers passed to the sequencer |
| ctl_rst | output | 1 | Reset for control registers 1, 2 and status |
| acc_cfg | output | 2 | Access code, configuration/interrupt/test group |
| acc_ctl0 | output | 2 | Access code, port and control-0 group |
| acc_ctl12 | output | 2 | Access code, control-1/2 and status group |
| acc_ram | output | 2 | Access code, command and result RAM |

## Verification
Freeze and stop can both start in the same cycle, and they drive the same hold outputs and access codes. The bench raises both requests before a single edge with no queue active. It expects both status bits set together, the holds asserted, and the stop access policy in force. It then drops stop alone and expects freeze to keep the holds while every access code returns to full. A second case puts a trigger pulse in the very cycle a freeze is sampled, where it must still pass, and puts one in the next cycle, where it must be dropped.

// File: rtl/adcfz_pkg.sv
package adcfz_pkg;
  typedef enum logic [1:0] {
    FZ_RUN  = 2'b00,
    FZ_WAIT = 2'b01,
    FZ_HOLD = 2'b10
  } fz_state_t;

  localparam logic [1:0] ACC_NONE = 2'b00;
  localparam logic [1:0] ACC_RO   = 2'b01;
  localparam logic [1:0] ACC_FULL = 2'b10;
endpackage

// File: rtl/adcfz_freeze_fsm.sv
module adcfz_freeze_fsm
  import adcfz_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frz_req,
  input  logic             frz_en,
  input  logic             q_active,
  input  logic             conv_busy,
  input  logic             conv_done,
  input  logic             qmode_chg,
  input  logic             q2_abort,
  input  logic [PTR_W-1:0] qptr,
  output logic             frozen,
  output logic             resume,
  output logic [PTR_W-1:0] saved_ptr
);
  fz_state_t        st_q, st_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             res_d, res_q;
  logic             want, cut_now, enter;

  assign want    = frz_req & frz_en;
  // conversion boundary reached, nothing in flight, or forced cut
  assign cut_now = ~q_active | ~conv_busy | conv_done | qmode_chg | q2_abort;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FZ_RUN:  if (want) st_d = cut_now ? FZ_HOLD : FZ_WAIT;
      FZ_WAIT: if (!want) st_d = FZ_RUN;
               else if (cut_now) st_d = FZ_HOLD;
      FZ_HOLD: if (!want) st_d = FZ_RUN;
      default: st_d = FZ_RUN;
    endcase
  end

  assign enter = (st_d == FZ_HOLD) && (st_q != FZ_HOLD);

  always_comb begin
    ptr_d = ptr_q;
    if (enter && q_active) ptr_d = qptr;
  end

  assign res_d = (st_q == FZ_HOLD) && (st_d == FZ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FZ_RUN;
      ptr_q <= '0;
      res_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
      if (enter) ptr_q <= ptr_d;
    end
  end

  assign frozen    = (st_q == FZ_HOLD);
  assign resume    = res_q;
  assign saved_ptr = ptr_q;

  AST_FRZ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(frz_req && frz_en)); // R1
  AST_IDLE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FZ_RUN && frz_req && frz_en && !q_active) |=> frozen); // R2
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FZ_WAIT && frz_req && frz_en && q_active && conv_busy && !conv_done
     && !qmode_chg && !q2_abort) |=> !frozen); // R3
  AST_CUT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FZ_WAIT && frz_req && frz_en && (qmode_chg || q2_abort)) |=> frozen); // R4
  AST_PTR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(saved_ptr)); // R6
  AST_RESUME_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R10
  AST_RESUME_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume) |-> (!frozen && $past(frozen))); // R10
endmodule

// File: rtl/adcfz_stop_ctl.sv
module adcfz_stop_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic stop_en,
  output logic stopped
);
  logic stp_d, stp_q;

  always_comb stp_d = stop_req & stop_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stp_q <= 1'b0;
    else        stp_q <= stp_d;
  end

  assign stopped = stp_q;

  AST_STOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_en |=> !stopped); // R8
endmodule

// File: rtl/adcfz_trig_gate.sv
module adcfz_trig_gate #(
  parameter int N_TRIG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frozen,
  input  logic [N_TRIG-1:0] trig_in,
  output logic [N_TRIG-1:0] trig_cap
);
  logic [N_TRIG-1:0] cap_d, cap_q;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_lane
    always_comb cap_d[g] = trig_in[g] & ~frozen;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q[g] <= 1'b0;
      else        cap_q[g] <= cap_d[g];
    end
  end

  assign trig_cap = cap_q;

  AST_TRIG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> (trig_cap == '0)); // R7
endmodule

// File: rtl/adcfz_access.sv
module adcfz_access
  import adcfz_pkg::*;
(
  input  logic       stopped,
  output logic [1:0] acc_cfg,
  output logic [1:0] acc_ctl0,
  output logic [1:0] acc_ctl12,
  output logic [1:0] acc_ram
);
  always_comb begin
    acc_cfg   = ACC_FULL;
    acc_ctl0  = ACC_FULL;
    acc_ctl12 = ACC_FULL;
    acc_ram   = ACC_FULL;
    if (stopped) begin
      acc_ctl0  = ACC_RO;
      acc_ctl12 = ACC_RO;
      acc_ram   = ACC_NONE;
    end
  end

  always_comb begin
    if (stopped) AST_RAM_CLOSED: assert (acc_ram == ACC_NONE); // R9
  end
endmodule

// File: rtl/adcfz_ctl.sv
module adcfz_ctl
  import adcfz_pkg::*;
#(
  parameter int PTR_W  = 6,
  parameter int N_TRIG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frz_req,
  input  logic              frz_en,
  input  logic              stop_en,
  input  logic              stop_req,
  input  logic              q_active,
  input  logic              conv_busy,
  input  logic              conv_done,
  input  logic              qmode_chg,
  input  logic              q2_abort,
  input  logic [N_TRIG-1:0] trig_in,
  input  logic [PTR_W-1:0]  qptr,
  output logic              frozen,
  output logic              stopped,
  output logic              qclk_hold,
  output logic              pit_hold,
  output logic [PTR_W-1:0]  saved_ptr,
  output logic              resume,
  output logic [N_TRIG-1:0] trig_cap,
  output logic              ctl_rst,
  output logic [1:0]        acc_cfg,
  output logic [1:0]        acc_ctl0,
  output logic [1:0]        acc_ctl12,
  output logic [1:0]        acc_ram
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rsync_q;
  logic              rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_ni = rsync_q[SYNC_N-1];

  adcfz_freeze_fsm #(.PTR_W(PTR_W)) u_frz (
    .clk(clk), .rst_n(rst_ni), .frz_req(frz_req), .frz_en(frz_en),
    .q_active(q_active), .conv_busy(conv_busy), .conv_done(conv_done),
    .qmode_chg(qmode_chg), .q2_abort(q2_abort), .qptr(qptr),
    .frozen(frozen), .resume(resume), .saved_ptr(saved_ptr)
  );

  adcfz_stop_ctl u_stop (
    .clk(clk), .rst_n(rst_ni), .stop_req(stop_req), .stop_en(stop_en),
    .stopped(stopped)
  );

  adcfz_trig_gate #(.N_TRIG(N_TRIG)) u_trig (
    .clk(clk), .rst_n(rst_ni), .frozen(frozen), .trig_in(trig_in),
    .trig_cap(trig_cap)
  );

  adcfz_access u_acc (
    .stopped(stopped), .acc_cfg(acc_cfg), .acc_ctl0(acc_ctl0),
    .acc_ctl12(acc_ctl12), .acc_ram(acc_ram)
  );

  always_comb begin
    qclk_hold = frozen | stopped;
    pit_hold  = frozen | stopped;
    ctl_rst   = stopped;
  end

  AST_FRZ_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    frozen |-> (qclk_hold && pit_hold)); // R5
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    stopped |-> (pit_hold && ctl_rst)); // R8
  AST_FRZ_NO_RAM_CUT: assert property (@(posedge clk) disable iff (!rst_ni)
    (frozen && !stopped) |-> (acc_ram == ACC_FULL)); // R9
endmodule

// File: tb/sim_adcfz_ctl.sv
module sim_adcfz_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 6;
  localparam int NT = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic frz_req, frz_en, stop_en, stop_req, q_active, conv_busy, conv_done;
  logic qmode_chg, q2_abort, ctl_rst, frozen, stopped, qclk_hold, pit_hold, resume;
  logic [NT-1:0] trig_in, trig_cap;
  logic [PW-1:0] qptr, saved_ptr;
  logic [1:0] acc_cfg, acc_ctl0, acc_ctl12, acc_ram;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcfz_ctl #(.PTR_W(PW), .N_TRIG(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .frz_req(frz_req), .frz_en(frz_en),
    .stop_en(stop_en), .stop_req(stop_req), .q_active(q_active),
    .conv_busy(conv_busy), .conv_done(conv_done), .qmode_chg(qmode_chg),
    .q2_abort(q2_abort), .trig_in(trig_in), .qptr(qptr), .frozen(frozen),
    .stopped(stopped), .qclk_hold(qclk_hold), .pit_hold(pit_hold),
    .saved_ptr(saved_ptr), .resume(resume), .trig_cap(trig_cap),
    .ctl_rst(ctl_rst), .acc_cfg(acc_cfg), .acc_ctl0(acc_ctl0),
    .acc_ctl12(acc_ctl12), .acc_ram(acc_ram)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    frz_req = 0; frz_en = 0; stop_en = 0; stop_req = 0; q_active = 0;
    conv_busy = 0; conv_done = 0; qmode_chg = 0; q2_abort = 0;
    trig_in = '0; qptr = '0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    frz_en = 1; frz_req = 1; stop_en = 1; stop_req = 1; trig_in = '1;
    step(); step();
    chk("R11 frozen", frozen, 0);
    chk("R11 stopped", stopped, 0);
    chk("R11 holds", {qclk_hold, pit_hold}, 0);
    chk("R11 trig_cap", trig_cap, 0);
    chk("R11 saved_ptr", saved_ptr, 0);
    chk("R11 resume", resume, 0);
    chk("R11 acc_ram", acc_ram, 2'b10);
    idle_inputs();
    rst_n = 1;
    repeat (4) step();
  endtask

  task automatic t_disabled();
    frz_en = 0; frz_req = 1;
    repeat (3) step();
    chk("R1 frozen with enable low", frozen, 0);
    chk("R1 holds with enable low", qclk_hold, 0);
    frz_req = 0; step();
  endtask

  task automatic t_idle_and_resume();
    qptr = 6'd9; q_active = 0;
    frz_en = 1; frz_req = 1;
    step();
    chk("R2 frozen after one edge", frozen, 1);
    chk("R5 qclk_hold", qclk_hold, 1);
    chk("R5 pit_hold", pit_hold, 1);
    chk("R6 no capture when idle", saved_ptr, 0);
    frz_req = 0;
    step();
    chk("R5 released", {frozen, qclk_hold, pit_hold}, 0);
    chk("R10 resume up", resume, 1);
    step();
    chk("R10 resume one cycle", resume, 0);
  endtask

  task automatic t_wait_done();
    q_active = 1; conv_busy = 1; qptr = 6'd21;
    frz_en = 1; frz_req = 1;
    step();
    chk("R3 waiting", frozen, 0);
    step();
    chk("R3 still waiting", frozen, 0);
    conv_done = 1;
    step();
    chk("R3 frozen after done", frozen, 1);
    chk("R6 pointer captured", saved_ptr, 21);
    conv_done = 0; conv_busy = 0; qptr = 6'd3;
    step();
    chk("R6 pointer held", saved_ptr, 21);
    frz_req = 0;
    step();
    chk("R10 resume", resume, 1);
    chk("R10 pointer at resume", saved_ptr, 21);
    q_active = 0;
    step();
  endtask

  task automatic t_cut(input bit use_abort);
    q_active = 1; conv_busy = 1; qptr = use_abort ? 6'd40 : 6'd17;
    frz_en = 1; frz_req = 1;
    step();
    chk("R4 waiting before cut", frozen, 0);
    if (use_abort) q2_abort = 1; else qmode_chg = 1;
    step();
    chk(use_abort ? "R4 abort cut" : "R4 mode cut", frozen, 1);
    chk("R6 pointer at cut", saved_ptr, use_abort ? 40 : 17);
    q2_abort = 0; qmode_chg = 0; frz_req = 0; conv_busy = 0; q_active = 0;
    step(); step();
  endtask

  task automatic t_trig();
    frz_en = 1; frz_req = 1; trig_in = 2'b11;
    step();
    chk("R7 trigger at entry edge passes", trig_cap, 2'b11);
    trig_in = 2'b01;
    step();
    chk("R7 trigger dropped while frozen", trig_cap, 2'b00);
    frz_req = 0; trig_in = 2'b10;
    step();
    chk("R7 trigger at exit edge dropped", trig_cap, 2'b00);
    step();
    chk("R7 trigger passes when running", trig_cap, 2'b10);
    trig_in = '0;
    step();
  endtask

  task automatic t_stop();
    stop_en = 0; stop_req = 1;
    step();
    chk("R8 stop disabled", stopped, 0);
    stop_en = 1;
    step();
    chk("R8 stopped", stopped, 1);
    chk("R8 holds and ctl_rst", {pit_hold, qclk_hold, ctl_rst}, 3'b111);
    chk("R9 cfg full", acc_cfg, 2'b10);
    chk("R9 ctl0 ro", acc_ctl0, 2'b01);
    chk("R9 ctl12 ro", acc_ctl12, 2'b01);
    chk("R9 ram none", acc_ram, 2'b00);
    chk("R1 no freeze from stop", frozen, 0);
    stop_req = 0;
    step();
    chk("R8 stop left", {stopped, ctl_rst, pit_hold}, 0);
    chk("R9 ram back", acc_ram, 2'b10);
  endtask

  task automatic t_both();
    frz_en = 1; frz_req = 1; stop_en = 1; stop_req = 1; q_active = 0;
    step();
    chk("R5 both frozen", frozen, 1);
    chk("R8 both stopped", stopped, 1);
    chk("R9 stop policy wins", {acc_ctl0, acc_ram}, 4'b0100);
    stop_req = 0;
    step();
    chk("R5 freeze keeps holds", {frozen, qclk_hold, pit_hold}, 3'b111);
    chk("R9 full under freeze", {acc_cfg, acc_ctl0, acc_ctl12, acc_ram}, 8'b10101010);
    frz_req = 0;
    step();
    chk("R5 all released", {frozen, stopped, pit_hold}, 0);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_idle_and_resume();
    t_wait_done();
    t_cut(0);
    t_cut(1);
    t_trig();
    t_stop();
    t_both();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule